// File: doc/BRIEF.md
# SD Card Command Issue Engine

This block sends a single command to an SD card over the one-wire CMD line and collects the card's reply. Software first loads a 32-bit argument and, if it wants, a timeout value. It then writes a command word. That word holds the command index, the response kind and a start flag. The engine builds a 48-bit frame from these fields, appends a CRC7 and shifts the frame out most significant bit first, one bit per card clock. The block runs in the card clock domain; generating that clock is outside the block.

After the frame, the engine either finishes at once or listens on CMD for the card's start bit. It accepts a 48-bit or a 136-bit reply. For a short reply it checks the CRC7, and it can then wait until the card releases its busy hold on DAT0. Errors and the end of a busy hold are recorded in a status register that software clears by writing ones. The start flag drops when the command is over. A fail flag next to it tells software that the status register holds an error for this command.

Register word addresses on `reg_addr`: 0 command word, 1 argument, 2 timeout, 3 status, 4 configuration, 5 to 8 response words 0 to 3.

Top module: `sd_cmd_issuer`

## Requirements
- R1: After reset, the command word (address 0) reads 0, the status register (address 3) reads 0, `cmd_oe` is low and `irq` is low.
- R2: A command word write with bit 15 set starts a command. `cmd_oe` is high for exactly 48 cycles, starting the cycle after the write. During those cycles `cmd_o` carries, MSB first: 0, 1, the index (bits 5:0 of the word), the 32-bit argument, CRC7 (x^7+x^3+1) over those 40 bits, then 1. At all other times `cmd_oe` is low.
- R3: Bit 15 of the command word reads 1 while a command runs. When bit 10 (no response) is set, bit 15 reads 0 in the first cycle after the last frame bit, and bit 14 (fail) reads 0.
- R4: A write to the command word while bit 15 reads 1 is ignored. The running frame and the stored index are unchanged.
- R5: A start request with both bit 9 (long response) and bit 11 (busy wait) set is refused. Bit 15 stays 0, bit 14 reads 1 and `cmd_oe` stays low.
- R6: Let T be the timeout register value (address 2). After the end bit, a response start bit seen in any of wait cycles 0 to T is accepted. If no start bit is seen, status bit 6 is set, bit 14 is set and bit 15 clears.
- R7: A short response is 48 bits, the start bit included. Its bits 39:8 go to response word 0, and words 1 to 3 read 0. If the CRC7 over its first 40 bits differs from its bits 7:1, status bit 4 is set and bit 14 reads 1 when bit 15 clears.
- R8: With bit 9 set, a 136-bit response is captured and its bits 127:0 fill response words 0 (bits 31:0) to 3 (bits 127:96). No CRC is checked.
- R9: With bit 11 set, after the response bit 15 stays 1 while `dat0_i` is low. When `dat0_i` goes high, status bit 10 is set and bit 15 clears.
- R10: Status bits 4, 6 and 10 clear when a 1 is written to them at address 3. Writing 0 leaves them set.
- R11: `irq` is high exactly when configuration bit 10 (address 4) and status bit 10 are both 1.
- R12: Starting a new command clears bit 14. Bits 6 and 7 (read-data and write-data marks) are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cmd_i | input | 1 | CMD line as sampled from the pad |
| cmd_o | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| dat0_i | input | 1 | DAT0 line, low while the card is busy |
| irq | output | 1 | Busy-end interrupt |

## Verification
The bench plays the card. It goes after the timeout boundary: a start bit in the last allowed wait cycle must be taken, and one a cycle later must time out, so an off-by-one counter fails one of the two cases. A corrupted CRC must raise the CRC error without losing the captured reply. A long-plus-busy request must be refused, and a design that still launched it would drive the line where none is expected. A command word written mid-frame must not restart or alter the frame, which a design without the guard would show as a changed bit stream. In the busy wait, clearing the start flag before DAT0 rises, or before the end bit, shows up in the mid-busy read-back.

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer #(
  parameter int TOUT_W     = 32,
  parameter int BUSY_GUARD = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        cmd_i,
  output logic        cmd_o,
  output logic        cmd_oe,
  input  logic        dat0_i,
  output logic        irq
);
  localparam int CNT_W = 8;
  localparam logic [3:0] A_CMD = 4'd0, A_ARG = 4'd1, A_TOUT = 4'd2,
                         A_STAT = 4'd3, A_CFG = 4'd4;

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_WAIT, S_RECV, S_BUSY} st_t;
  st_t st_q;

  logic [5:0]        idx_q;
  logic              rdf_q, wrf_q, long_q, nore_q, busy_q, start_q, fail_q;
  logic [31:0]       arg_q;
  logic [TOUT_W-1:0] tout_q, tcnt_q;
  logic              irq_en_q;
  logic              stat_crc, stat_to, stat_bd;
  logic [127:0]      rsp_q;
  logic [47:0]       tx_q;
  logic [126:0]      rx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              err_q;

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  wire         wr_cmd  = reg_wr && reg_addr == A_CMD && !start_q;
  wire         bad_mix = reg_wdata[9] && reg_wdata[11];
  wire         launch  = wr_cmd && reg_wdata[15] && !bad_mix;
  wire         reject  = wr_cmd && reg_wdata[15] && bad_mix;
  wire [39:0]  hdr     = {2'b01, reg_wdata[5:0], arg_q};
  wire [127:0] rx_next = {rx_q, cmd_i};
  wire         last    = cnt_q == '0;

  wire timeout_now = st_q == S_WAIT && cmd_i && tcnt_q == '0;
  wire recv_done   = st_q == S_RECV && last;
  wire crc_bad_now = recv_done && !long_q &&
                     crc7({1'b0, rx_next[46:8]}) != rx_next[7:1];
  wire busy_end    = st_q == S_BUSY && last && dat0_i;
  wire finish      = (st_q == S_SEND && last && nore_q) || timeout_now ||
                     (recv_done && !busy_q) || busy_end;

  wire [2:0] clr = (reg_wr && reg_addr == A_STAT) ?
                   {reg_wdata[10], reg_wdata[6], reg_wdata[4]} : 3'b000;

  assign cmd_o  = tx_q[47];
  assign cmd_oe = st_q == S_SEND;
  assign irq    = irq_en_q && stat_bd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {idx_q, rdf_q, wrf_q, long_q, nore_q, busy_q} <= '0;
      start_q <= 1'b0;
      fail_q  <= 1'b0;
    end else if (wr_cmd) begin
      idx_q   <= reg_wdata[5:0];
      rdf_q   <= reg_wdata[6];
      wrf_q   <= reg_wdata[7];
      long_q  <= reg_wdata[9];
      nore_q  <= reg_wdata[10];
      busy_q  <= reg_wdata[11];
      start_q <= launch;
      fail_q  <= reject;
    end else if (finish) begin
      start_q <= 1'b0;
      fail_q  <= err_q || crc_bad_now || timeout_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_q    <= '0;
      tout_q   <= '0;
      irq_en_q <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == A_ARG)  arg_q    <= reg_wdata;
      if (reg_addr == A_TOUT) tout_q   <= reg_wdata[TOUT_W-1:0];
      if (reg_addr == A_CFG)  irq_en_q <= reg_wdata[10];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_crc <= 1'b0;
      stat_to  <= 1'b0;
      stat_bd  <= 1'b0;
    end else begin
      stat_crc <= crc_bad_now || (stat_crc && !clr[0]);
      stat_to  <= timeout_now || (stat_to && !clr[1]);
      stat_bd  <= busy_end    || (stat_bd && !clr[2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      tx_q   <= '1;
      rx_q   <= '0;
      rsp_q  <= '0;
      cnt_q  <= '0;
      tcnt_q <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (launch) begin
          tx_q  <= {hdr, crc7(hdr), 1'b1};
          cnt_q <= CNT_W'(47);
          err_q <= 1'b0;
          st_q  <= S_SEND;
        end
        S_SEND: begin
          tx_q <= {tx_q[46:0], 1'b1};
          if (last) begin
            tcnt_q <= tout_q;
            st_q   <= nore_q ? S_IDLE : S_WAIT;
          end else cnt_q <= cnt_q - 1'b1;
        end
        S_WAIT: begin
          if (!cmd_i) begin
            cnt_q <= long_q ? CNT_W'(134) : CNT_W'(46);
            st_q  <= S_RECV;
          end else if (tcnt_q == '0) st_q <= S_IDLE;
          else tcnt_q <= tcnt_q - 1'b1;
        end
        S_RECV: begin
          rx_q <= rx_next[126:0];
          if (last) begin
            rsp_q <= long_q ? rx_next : {96'b0, rx_next[39:8]};
            if (crc_bad_now) err_q <= 1'b1;
            cnt_q <= CNT_W'(BUSY_GUARD);
            st_q  <= busy_q ? S_BUSY : S_IDLE;
          end else cnt_q <= cnt_q - 1'b1;
        end
        S_BUSY: begin
          if (!last) cnt_q <= cnt_q - 1'b1;
          else if (dat0_i) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = {16'b0, start_q, fail_q, 2'b00, busy_q, nore_q, long_q,
                            1'b0, wrf_q, rdf_q, idx_q};
      A_ARG:   reg_rdata = arg_q;
      A_TOUT:  reg_rdata = 32'(tout_q);
      A_STAT:  reg_rdata = {21'b0, stat_bd, 3'b0, stat_to, 1'b0, stat_crc, 4'b0};
      A_CFG:   reg_rdata = {21'b0, irq_en_q, 10'b0};
      4'd5:    reg_rdata = rsp_q[31:0];
      4'd6:    reg_rdata = rsp_q[63:32];
      4'd7:    reg_rdata = rsp_q[95:64];
      4'd8:    reg_rdata = rsp_q[127:96];
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sd_cmd_issuer_chk.sv
module sd_cmd_issuer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_oe,
  input logic       start_q,
  input logic       long_q,
  input logic       busy_q,
  input logic       stat_to,
  input logic       stat_bd,
  input logic       reg_wr,
  input logic [3:0] reg_addr,
  input logic [5:0] idx_q
);
  logic [7:0] oe_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_len <= '0;
    else        oe_len <= cmd_oe ? oe_len + 8'd1 : 8'd0;
  end

  AST_OE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> start_q); // R2
  AST_OE_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_oe) |-> oe_len == 8'd48); // R2
  AST_OE_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    oe_len <= 8'd48); // R2
  AST_CMDW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && reg_wr && reg_addr == 4'd0) |=> $stable(idx_q)); // R4
  AST_NO_LONG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> !(long_q && busy_q)); // R5
  AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_to) |-> !start_q); // R6
  AST_BUSY_END_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_bd) |-> !start_q); // R9
endmodule

bind sd_cmd_issuer sd_cmd_issuer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_oe(cmd_oe), .start_q(start_q),
  .long_q(long_q), .busy_q(busy_q), .stat_to(stat_to), .stat_bd(stat_bd),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .idx_q(idx_q)
);

// File: tb/sd_cmd_issuer_tb_top.sv
`timescale 1ns/1ps
module sd_cmd_issuer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_i = 1'b1;
  logic        cmd_o, cmd_oe;
  logic        dat0_i = 1'b1;
  logic        irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  bit exp_q[$];

  always #4 clk = ~clk;

  sd_cmd_issuer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_i(cmd_i),
    .cmd_o(cmd_o), .cmd_oe(cmd_oe), .dat0_i(dat0_i), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [39:0] m);
    logic [46:0] r;
    r = {m, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  task automatic push_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [47:0] f;
    f = {2'b01, idx, arg, ref_crc({2'b01, idx, arg}), 1'b1};
    for (int i = 47; i >= 0; i--) exp_q.push_back(f[i]);
  endtask

  // per-clock reference of the line: every driven bit must be the next expected one
  always @(negedge clk) begin
    if (rst_n && cmd_oe === 1'b1) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 line driven outside a frame", 1, 0);
      else begin
        bit b;
        b = exp_q.pop_front();
        chk(cmd_o === b, "R2 frame bit", cmd_o, b);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_now(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic card(input int gap, input int nbits, input logic [135:0] fr,
                      input int busy_cyc);
    logic [31:0] d;
    while (cmd_oe !== 1'b1) @(negedge clk);
    while (cmd_oe === 1'b1) @(negedge clk);
    repeat (gap) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      cmd_i = fr[i];
      @(negedge clk);
    end
    cmd_i = 1'b1;
    if (busy_cyc > 0) begin
      dat0_i = 1'b0;
      repeat (busy_cyc / 2) @(negedge clk);
      rd_now(4'd0, d);
      chk(d[15] == 1'b1, "R9 start held during busy", d[15], 1);
      rd_now(4'd3, d);
      chk(d[10] == 1'b0, "R9 busy-end not yet set", d[10], 0);
      repeat (busy_cyc - busy_cyc / 2) @(negedge clk);
      dat0_i = 1'b1;
    end
  endtask

  task automatic wait_done(output logic [31:0] d);
    int k;
    k = 0;
    @(negedge clk);
    rd_now(4'd0, d);
    while (d[15] && k < 2000) begin
      @(negedge clk);
      rd_now(4'd0, d);
      k++;
    end
    chk(k < 2000, "R3 command never finished", k, 0);
  endtask

  function automatic logic [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] st,
                                            input bit corrupt);
    logic [6:0] c;
    c = ref_crc({2'b00, idx, st}) ^ {6'b0, corrupt};
    return {88'b0, 2'b00, idx, st, c, 1'b1};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [127:0] pay;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_now(4'd0, d); chk(d == 0, "R1 command word after reset", d, 0);
    rd_now(4'd3, d); chk(d == 0, "R1 status after reset", d, 0);
    chk(cmd_oe === 1'b0, "R1 cmd_oe after reset", cmd_oe, 0);
    chk(irq === 1'b0, "R1 irq after reset", irq, 0);

    // R2 R3 no-response command
    wr(4'd1, 32'h0000_0000);
    push_frame(6'd0, 32'h0);
    wr(4'd0, 32'h0000_8400);
    rd_now(4'd0, d); chk(d[15] == 1'b1, "R3 start set while running", d[15], 1);
    while (cmd_oe === 1'b1) @(negedge clk);
    rd_now(4'd0, d);
    chk(d[15] == 1'b0, "R3 start clear right after frame", d[15], 0);
    chk(d[14] == 1'b0, "R3 no fail", d[14], 0);
    chk(exp_q.size() == 0, "R2 frame length", exp_q.size(), 0);

    // R4 write during a frame is ignored
    wr(4'd1, 32'hA5C3_0F96);
    push_frame(6'd9, 32'hA5C3_0F96);
    wr(4'd0, 32'h0000_8409);
    repeat (5) @(negedge clk);
    wr(4'd0, 32'h0000_8422);
    rd_now(4'd0, d); chk(d[5:0] == 6'd9, "R4 index kept", d[5:0], 9);
    while (cmd_oe === 1'b1) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(exp_q.size() == 0, "R4 single frame only", exp_q.size(), 0);

    // R7 short response, good CRC
    wr(4'd2, 32'd20);
    wr(4'd1, 32'h1234_5678);
    push_frame(6'd17, 32'h1234_5678);
    fork
      wr(4'd0, 32'h0000_8011);
      card(3, 48, short_rsp(6'd17, 32'hCAFE_0900, 1'b0), 0);
    join
    wait_done(d);
    chk(d[14] == 1'b0, "R7 no fail on good CRC", d[14], 0);
    rd_now(4'd3, d); chk(d == 0, "R7 no status on good CRC", d, 0);
    rd_now(4'd5, d); chk(d == 32'hCAFE_0900, "R7 response word 0", d, 32'hCAFE_0900);
    rd_now(4'd6, d); chk(d == 0, "R7 response word 1 zero", d, 0);
    rd_now(4'd8, d); chk(d == 0, "R7 response word 3 zero", d, 0);

    // R7 bad CRC, then R10 write-one-to-clear
    push_frame(6'd13, 32'h1234_5678);
    fork
      wr(4'd0, 32'h0000_800D);
      card(0, 48, short_rsp(6'd13, 32'h0BAD_F00D, 1'b1), 0);
    join
    wait_done(d);
    chk(d[14] == 1'b1, "R7 fail on CRC error", d[14], 1);
    rd_now(4'd3, d); chk(d == 32'h10, "R7 CRC status bit 4", d, 32'h10);
    rd_now(4'd5, d); chk(d == 32'h0BAD_F00D, "R7 response kept on CRC error", d, 32'h0BAD_F00D);
    wr(4'd3, 32'h0);
    rd_now(4'd3, d); chk(d == 32'h10, "R10 zero write keeps bit", d, 32'h10);
    wr(4'd3, 32'h10);
    rd_now(4'd3, d); chk(d == 0, "R10 one write clears bit", d, 0);

    // R6 timeout boundary: start bit at wait cycle T accepted
    wr(4'd2, 32'd5);
    push_frame(6'd8, 32'h1234_5678);
    fork
      wr(4'd0, 32'h0000_8008);
      card(5, 48, short_rsp(6'd8, 32'h0000_01AA, 1'b0), 0);
    join
    wait_done(d);
    chk(d[14] == 1'b0, "R6 start bit at limit accepted", d[14], 0);
    rd_now(4'd3, d); chk(d == 0, "R6 no timeout at limit", d, 0);
    rd_now(4'd5, d); chk(d == 32'h0000_01AA, "R6 response at limit", d, 32'h1AA);

    // R6 one cycle later times out
    push_frame(6'd8, 32'h1234_5678);
    fork
      wr(4'd0, 32'h0000_8008);
      card(6, 48, short_rsp(6'd8, 32'h0000_01AA, 1'b0), 0);
    join
    wait_done(d);
    chk(d[14] == 1'b1, "R6 fail on timeout", d[14], 1);
    rd_now(4'd3, d); chk(d == 32'h40, "R6 timeout status bit 6", d, 32'h40);
    wr(4'd3, 32'h40);

    // R12 fail cleared by new launch, data marks stored
    push_frame(6'd3, 32'h1234_5678);
    wr(4'd0, 32'h0000_84C3);
    rd_now(4'd0, d); chk(d[14] == 1'b0, "R12 fail cleared at launch", d[14], 0);
    wait_done(d);
    chk(d[7:6] == 2'b11, "R12 data marks read back", d[7:6], 3);
    chk(d[14] == 1'b0, "R12 no fail", d[14], 0);

    // R8 long response
    wr(4'd2, 32'd10);
    pay = {32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 32'h7654_3211};
    push_frame(6'd2, 32'h1234_5678);
    fork
      wr(4'd0, 32'h0000_8202);
      card(2, 136, {1'b0, 1'b1, 6'h3F, pay}, 0);
    join
    wait_done(d);
    chk(d[14] == 1'b0, "R8 no CRC check on long", d[14], 0);
    rd_now(4'd5, d); chk(d == pay[31:0], "R8 word 0", d, pay[31:0]);
    rd_now(4'd6, d); chk(d == pay[63:32], "R8 word 1", d, pay[63:32]);
    rd_now(4'd7, d); chk(d == pay[95:64], "R8 word 2", d, pay[95:64]);
    rd_now(4'd8, d); chk(d == pay[127:96], "R8 word 3", d, pay[127:96]);
    rd_now(4'd3, d); chk(d == 0, "R8 no status", d, 0);

    // R5 long plus busy refused
    wr(4'd0, 32'h0000_8A05);
    rd_now(4'd0, d);
    chk(d[15] == 1'b0, "R5 not started", d[15], 0);
    chk(d[14] == 1'b1, "R5 fail set", d[14], 1);
    repeat (60) @(negedge clk);
    chk(cmd_oe === 1'b0, "R5 line idle", cmd_oe, 0);

    // R9 busy wait, then R11 interrupt gating
    push_frame(6'd7, 32'h1234_5678);
    fork
      wr(4'd0, 32'h0000_8807);
      card(1, 48, short_rsp(6'd7, 32'h0000_0700, 1'b0), 20);
    join
    wait_done(d);
    chk(d[14] == 1'b0, "R9 no fail", d[14], 0);
    rd_now(4'd3, d); chk(d == 32'h400, "R9 busy-end bit 10", d, 32'h400);
    chk(irq === 1'b0, "R11 irq masked", irq, 0);
    wr(4'd4, 32'h400);
    #1; chk(irq === 1'b1, "R11 irq enabled", irq, 1);
    wr(4'd3, 32'h400);
    #1; chk(irq === 1'b0, "R11 irq after clear", irq, 0);
    rd_now(4'd3, d); chk(d == 0, "R10 busy-end cleared", d, 0);
    chk(exp_q.size() == 0, "R2 all frames sent", exp_q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule